// File: doc/BRIEF.md
# Split-Access 64-bit Control Register Bridge

This block joins a 32-bit access port to a small bank of 64-bit control registers. Every 64-bit register takes two 32-bit accesses. Address bit 2 selects the half. A single 32-bit holding latch sits between the two halves and serves both directions:

- **Writes:** a write to the low half only parks its data in the latch. The following write to the high half commits the latch and the new data together as one atomic 64-bit update.
- **Reads:** a read of the low half returns the low word and parks the high word in the latch. A read of the high half returns whatever the latch holds.

The register bank holds four address-translation windows and one control register:

- Each window has a base, a mask and a translated base.
- The translated base keeps only the page-number bits (written value bits 41:10).
- Only a fixed set of bits in the control register is writable.

A handful of offsets are reserved: they read as zero and drop writes. Any other offset is unmapped. A read of an unmapped offset returns all ones, and any access that decodes one raises an error flag in the response. Every access gets a response on the cycle after it is presented.

Top module: `csr_split_bridge`

## Requirements
- R1: After reset the holding latch, every window field and the control register are zero, and `rsp_valid` is low.
- R2: A write with `acc_addr[2]`=0 loads `acc_wdata` into the holding latch and changes no register. Its response has `rsp_err`=0.
- R3: A write with `acc_addr[2]`=1 commits the 64-bit value {`acc_wdata`, latch} to the register at the address with bit 2 cleared.
- R4: A read with `acc_addr[2]`=1 returns the holding latch for any address. Its response has `rsp_err`=0, and the read does not change the latch.
- R5: A read with `acc_addr[2]`=0 of a mapped register returns bits 31:0 of that register and loads bits 63:32 into the holding latch.
- R6: Window i (i=0..3) has its base at 0x000+0x40*i, its mask at 0x100+0x40*i and its translated base at 0x200+0x40*i. Base and mask keep 32 bits, and their upper halves read as zero.
- R7: A translated base stores bits 41:10 of the committed value. It reads back with bits 9:0 and 63:42 as zero.
- R8: The control register at 0x300 updates only the bits set in 64'h0000_001C_FF0F_C7FF. All other bits keep their previous value.
- R9: An unmapped offset read with bit 2 clear returns 32'hFFFF_FFFF with `rsp_err`=1 and leaves the latch unchanged. A high-half write to an unmapped offset sets `rsp_err`=1 and changes nothing.
- R10: The reserved offsets 0x340, 0x3C0, 0x400, 0x440, 0x480, 0x4C0, 0x500, 0x540 and 0x800 read as zero (so the latch becomes zero) and ignore writes. Accesses to them have `rsp_err`=0.
- R11: `rsp_valid` is high exactly in the cycle after each cycle in which `acc_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data (zero for writes, all ones on error) |
| rsp_err | output | 1 | Access decoded an unmapped offset |

## Verification
The assertions assume that `acc_valid`, `acc_write`, `acc_addr` and `acc_wdata` carry known values whenever reset is released. They also assume that one access occupies exactly one cycle with no back-pressure. The bench drives every input on the falling clock edge from a single process, starting from defined idle values. It issues one access per pulse with an idle cycle between accesses. It pairs low and high halves explicitly, so the latch contents at every high-half access are known. Unmapped and reserved offsets are hit both with bit 2 clear and with bit 2 set. This keeps the latch-preservation and no-decode rules observable at the response port.

// File: rtl/csr_split_bridge.sv
module csr_split_bridge #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_WIN   = 4,
  parameter logic [63:0] CTL_WMASK = 64'h0000_001C_FF0F_C7FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int unsigned STRIDE   = 'h40;
  localparam int unsigned BASE_OFF = 'h000;
  localparam int unsigned MASK_OFF = 'h100;
  localparam int unsigned TPFN_OFF = 'h200;
  localparam int unsigned CTL_OFF  = 'h300;
  localparam int unsigned PFN_LSB  = 10;

  logic [31:0] hold_q;
  logic [31:0] base_q [NUM_WIN];
  logic [31:0] mask_q [NUM_WIN];
  logic [31:0] tpfn_q [NUM_WIN];
  logic [63:0] ctl_q;

  logic [ADDR_W-1:0] reg_addr;
  logic [63:0]       wval;
  logic [63:0]       rd64;
  logic              mapped;
  logic              reserved;
  logic              hi_half;
  logic              commit;

  assign reg_addr = acc_addr & ~ADDR_W'(4);
  assign hi_half  = acc_addr[2];
  assign wval     = {acc_wdata, hold_q};
  assign commit   = acc_valid && acc_write && hi_half;

  always_comb begin
    reserved = 1'b0;
    case (reg_addr)
      ADDR_W'('h340), ADDR_W'('h3C0), ADDR_W'('h400), ADDR_W'('h440),
      ADDR_W'('h480), ADDR_W'('h4C0), ADDR_W'('h500), ADDR_W'('h540),
      ADDR_W'('h800): reserved = 1'b1;
      default:        reserved = 1'b0;
    endcase
  end

  always_comb begin
    rd64   = '0;
    mapped = reserved;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (reg_addr == ADDR_W'(BASE_OFF + i*STRIDE)) begin
        mapped = 1'b1;
        rd64   = {32'b0, base_q[i]};
      end
      if (reg_addr == ADDR_W'(MASK_OFF + i*STRIDE)) begin
        mapped = 1'b1;
        rd64   = {32'b0, mask_q[i]};
      end
      if (reg_addr == ADDR_W'(TPFN_OFF + i*STRIDE)) begin
        mapped = 1'b1;
        rd64   = {22'b0, tpfn_q[i], 10'b0};
      end
    end
    if (reg_addr == ADDR_W'(CTL_OFF)) begin
      mapped = 1'b1;
      rd64   = ctl_q;
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        mask_q[g] <= '0;
        tpfn_q[g] <= '0;
      end else if (commit) begin
        if (reg_addr == ADDR_W'(BASE_OFF + g*STRIDE)) base_q[g] <= wval[31:0];
        if (reg_addr == ADDR_W'(MASK_OFF + g*STRIDE)) mask_q[g] <= wval[31:0];
        if (reg_addr == ADDR_W'(TPFN_OFF + g*STRIDE)) tpfn_q[g] <= wval[PFN_LSB +: 32];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (commit && reg_addr == ADDR_W'(CTL_OFF)) begin
      ctl_q <= (ctl_q & ~CTL_WMASK) | (wval & CTL_WMASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (acc_valid && !hi_half) begin
      if (acc_write)   hold_q <= acc_wdata;
      else if (mapped) hold_q <= rd64[63:32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      if (acc_valid) begin
        if (acc_write) begin
          rsp_err <= hi_half && !mapped;
        end else if (hi_half) begin
          rsp_rdata <= hold_q;
        end else begin
          rsp_rdata <= mapped ? rd64[31:0] : 32'hFFFF_FFFF;
          rsp_err   <= !mapped;
        end
      end
    end
  end

  // R11
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  // R11
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);
  // R4
  latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr[2]) |=> (rsp_rdata == $past(hold_q) && !rsp_err));
  // R2
  low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !acc_addr[2]) |=> (hold_q == $past(acc_wdata) && $stable(ctl_q) && !rsp_err));
  // R8
  ctl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (((ctl_q ^ $past(ctl_q)) & ~CTL_WMASK) == 64'b0));
  // R9
  err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
endmodule

// File: tb/csr_split_bridge_tb.sv
`timescale 1ns/1ps
module csr_split_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  always #4 clk = ~clk;

  csr_split_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    logic        chk_data;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [31:0] expd, input logic experr, input logic cd, input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    e.data = expd; e.err = experr; e.chk_data = cd; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic experr, input string tag);
    issue(1'b1, a, d, 32'h0, experr, 1'b0, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] expd, input logic experr, input string tag);
    issue(1'b0, a, 32'h0, expd, experr, 1'b1, tag);
  endtask

  initial begin
    fork
      begin : monitor
        forever begin
          @(negedge clk);
          if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
              check(1'b0, "R11 unexpected response", 32'(rsp_valid), 32'h0);
            end else begin
              exp_t e;
              e = exp_q.pop_front();
              check(rsp_err === e.err, {e.tag, " err"}, 32'(rsp_err), 32'(e.err));
              if (e.chk_data)
                check(rsp_rdata === e.data, {e.tag, " data"}, rsp_rdata, e.data);
            end
          end
        end
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
          check(1'b0, "watchdog expired", 32'h0, 32'h1);
          $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);

    // R1 reset values
    rd(12'h004, 32'h0, 1'b0, "R1 latch reset");
    rd(12'h000, 32'h0, 1'b0, "R1 base0 reset");
    rd(12'h2C0, 32'h0, 1'b0, "R1 tbase3 reset");
    rd(12'h300, 32'h0, 1'b0, "R1 ctl reset");

    // R2 low-half write only latches
    wr(12'h040, 32'hAAAA_5555, 1'b0, "R2 low write");
    rd(12'h044, 32'hAAAA_5555, 1'b0, "R2 latch holds low data");
    rd(12'h040, 32'h0, 1'b0, "R2 base1 untouched");

    // R3 / R6 commit and map
    wr(12'h040, 32'h1234_5678, 1'b0, "R3 low");
    wr(12'h044, 32'hDEAD_BEEF, 1'b0, "R3 high");
    rd(12'h040, 32'h1234_5678, 1'b0, "R3 base1 committed");
    rd(12'h044, 32'h0, 1'b0, "R6 base upper zero");
    rd(12'h000, 32'h0, 1'b0, "R6 base0 distinct");
    wr(12'h1C0, 32'hFFF0_0000, 1'b0, "R6 mask low");
    wr(12'h1C4, 32'h0000_0001, 1'b0, "R6 mask high");
    rd(12'h1C0, 32'hFFF0_0000, 1'b0, "R6 mask3");
    rd(12'h180, 32'h0, 1'b0, "R6 mask2 distinct");

    // R7 translated base, R5 high half into latch
    wr(12'h280, 32'h1234_5FFF, 1'b0, "R7 low");
    wr(12'h284, 32'h0000_0ABC, 1'b0, "R7 high");
    rd(12'h280, 32'h1234_5C00, 1'b0, "R7 low bits cleared");
    rd(12'h284, 32'h0000_02BC, 1'b0, "R5 R7 upper via latch");

    // R8 control mask
    wr(12'h300, 32'hFFFF_FFFF, 1'b0, "R8 low");
    wr(12'h304, 32'hFFFF_FFFF, 1'b0, "R8 high");
    rd(12'h300, 32'hFF0F_C7FF, 1'b0, "R8 low masked");
    rd(12'h304, 32'h0000_001C, 1'b0, "R8 high masked");
    wr(12'h300, 32'h0000_0800, 1'b0, "R8 low");
    wr(12'h304, 32'h0000_0000, 1'b0, "R8 high");
    rd(12'h300, 32'h0000_0000, 1'b0, "R8 fixed bit ignored");

    // R9 unmapped
    rd(12'h280, 32'h1234_5C00, 1'b0, "R5 reload latch");
    rd(12'h010, 32'hFFFF_FFFF, 1'b1, "R9 unmapped read");
    rd(12'h004, 32'h0000_02BC, 1'b0, "R9 latch unchanged");
    rd(12'hFFC, 32'h0000_02BC, 1'b0, "R4 no decode on high read");
    wr(12'h600, 32'h0000_0005, 1'b0, "R2 low to unmapped");
    wr(12'h604, 32'h0000_0005, 1'b1, "R9 unmapped commit");

    // R10 reserved
    rd(12'h280, 32'h1234_5C00, 1'b0, "R5 reload latch");
    rd(12'h340, 32'h0, 1'b0, "R10 reserved read");
    rd(12'h004, 32'h0, 1'b0, "R10 latch zeroed");
    wr(12'h800, 32'h0000_0001, 1'b0, "R10 low");
    wr(12'h804, 32'h0000_0001, 1'b0, "R10 high");
    rd(12'h800, 32'h0, 1'b0, "R10 write ignored");

    // R4 latch shared by reads and writes
    wr(12'h0C0, 32'h1111_2222, 1'b0, "R4 low write");
    rd(12'h0C4, 32'h1111_2222, 1'b0, "R4 shared latch");
    rd(12'h0C0, 32'h0, 1'b0, "R2 base3 untouched");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all responses seen", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule